// File: doc/BRIEF.md
# Two-Wire Debug Serial Slave

This block is the serial front end of an on-chip debug port. An external master drives a serial clock line and shares a bidirectional data line with the block. Both lines are brought into the system clock domain through a short synchronizer and oversampled. The block ignores all line activity until it sees a start condition, which is a falling data line while the serial clock is high. From then on it frames the traffic into bytes of nine serial clock cycles each: eight carry data with the most significant bit first, and the ninth is left for internal work.

On a receive byte the block samples the data line on each rising serial clock edge. After the eighth edge it hands the assembled byte to the internal debug logic with a one-cycle strobe. At each ninth rising edge the debug logic states whether the next byte is a transmit byte and, if so, supplies it. The block then drives that byte onto the data line on the following falling edges and enables its output driver only during those eight data cycles. The command decoding, the debug register file and the pin sharing with other test functions sit outside this block.

Top module: `dbg2w_slave`

## Requirements
- R1: After reset the output enable `dbg_dat_oe` is 0, `rx_valid` is 0 and the block is idle, waiting for a start condition.
- R2: Before the first start condition, clock pulses and data changes on the lines produce no `rx_valid` strobe and never assert `dbg_dat_oe`.
- R3: A high-to-low change of the data line while the serial clock is steadily high is a start condition. It begins a new byte at bit count zero, and the first byte after a start is always a receive byte.
- R4: A low-to-high change of the data line while the serial clock is high has no effect. It neither ends nor restarts a transfer, and it does not change a bit already sampled.
- R5: In a receive byte the data line is sampled on each of eight rising serial clock edges, the first sample landing in bit 7 and the last in bit 0 of `rx_byte`. `rx_valid` is raised after the eighth rising edge and `rx_byte` carries the byte while it is high.
- R6: Each byte spans nine serial clock cycles. The ninth rising edge closes the byte, and the next byte starts at the falling edge that follows, so back-to-back bytes stay aligned.
- R7: At the ninth rising edge `next_is_read` is sampled (1 selects transmit) and, when it is 1, `tx_byte` is captured. The next byte then drives bit 7 first down to bit 0 onto `dbg_dat_o`, with each bit changed only after a falling serial clock edge and `dbg_dat_oe` at 1 during those eight data cycles.
- R8: `dbg_dat_oe` returns to 0 at the falling edge that opens the ninth cycle, and a transmit byte produces no `rx_valid` strobe.
- R9: When the master stops in the ninth cycle with the serial clock held high, the block stays quiet with `dbg_dat_oe` at 0 until a new start condition arrives.
- R10: A start condition in the middle of a byte discards the partial byte and restarts framing at bit count zero.
- R11: `rx_valid` is high for exactly one system clock cycle per received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| dbg_clk_i | input | 1 | Serial clock line from the master (asynchronous) |
| dbg_dat_i | input | 1 | Data line as seen at the pad (asynchronous) |
| next_is_read | input | 1 | Sampled at the ninth rising edge; 1 makes the next byte a transmit byte |
| tx_byte | input | DATA_W | Byte to transmit, captured with `next_is_read` |
| dbg_dat_o | output | 1 | Data value driven onto the line |
| dbg_dat_oe | output | 1 | Output enable for the data line driver |
| rx_byte | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_byte` |

## Verification
The bench builds the block with its default values, a byte width of 8 and a two-flop synchronizer, and runs the serial clock with a half period of eight system clocks. That ratio gives the three-cycle path through the synchronizer and edge detector enough room that every bit the block drives settles well inside the low phase. This lets the bench sample the line just before each rising edge, as a real master would. The eight-bit width makes every framing corner reachable within a few hundred serial cycles: back-to-back receive bytes, a turn to transmit and back, an idle stop in the ninth cycle, a restart in mid-byte, and harmless data rises while the clock is high.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } link_st_e;

    typedef enum logic {
        DIR_WR = 1'b0,
        DIR_RD = 1'b1
    } xfer_dir_e;

    // Synchronized view of one external line
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } line_ev_t;

    localparam int LINE_DAT  = 0;
    localparam int LINE_CLK  = 1;
    localparam int NUM_LINES = 2;

    function automatic line_ev_t mk_ev(input logic cur, input logic prev);
        line_ev_t e;
        e.lvl  = cur;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

    // Falling data while the clock was already high on the previous sample
    function automatic logic is_start(input line_ev_t c, input line_ev_t d);
        return c.lvl && !c.rise && d.fall;
    endfunction

endpackage

// File: rtl/dbg2w_line_sync.sv
module dbg2w_line_sync
    import dbg2w_pkg::*;
#(
    parameter int   STAGES   = 2,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     raw,
    output line_ev_t ev
);

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{IDLE_LVL}};
            prev  <= IDLE_LVL;
        end else begin
            chain <= {chain[STAGES-2:0], raw};
            prev  <= chain[STAGES-1];
        end
    end

    assign ev = mk_ev(chain[STAGES-1], prev);

endmodule

// File: rtl/dbg2w_frame_ctrl.sv
module dbg2w_frame_ctrl
    import dbg2w_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         clk_ev,
    input  line_ev_t         dat_ev,
    input  logic             next_is_read,
    output link_st_e         state,
    output xfer_dir_e        dir,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             start_det,
    output logic             sample_en,
    output logic             byte_done,
    output logic             tx_load,
    output logic             drive_en,
    output logic             drive_off
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] NINTH    = CNT_W'(DATA_W);

    logic active;
    logic data_cyc;

    always_comb begin
        start_det = is_start(clk_ev, dat_ev);
        active    = (state == ST_XFER) && !start_det;
        data_cyc  = (bit_cnt != NINTH);
        sample_en = active && clk_ev.rise && data_cyc && (dir == DIR_WR);
        byte_done = sample_en && (bit_cnt == LAST_BIT);
        tx_load   = active && clk_ev.rise && !data_cyc && next_is_read;
        drive_en  = active && clk_ev.fall && data_cyc && (dir == DIR_RD);
        drive_off = start_det || (clk_ev.fall && !drive_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            dir     <= DIR_WR;
            bit_cnt <= '0;
        end else if (start_det) begin
            state   <= ST_XFER;
            dir     <= DIR_WR;
            bit_cnt <= '0;
        end else if (active && clk_ev.rise) begin
            if (data_cyc) begin
                bit_cnt <= bit_cnt + 1'b1;
            end else begin
                bit_cnt <= '0;
                dir     <= next_is_read ? DIR_RD : DIR_WR;
            end
        end
    end

endmodule

// File: rtl/dbg2w_shifter.sv
module dbg2w_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dat_lvl,
    input  logic              sample_en,
    input  logic              byte_done,
    input  logic              tx_load,
    input  logic              drive_en,
    input  logic              drive_off,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              dat_o,
    output logic              dat_oe
);

    logic [DATA_W-2:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_next;

    assign rx_next = {rx_sh, dat_lvl};

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh    <= '0;
            tx_sh    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            dat_o    <= 1'b1;
            dat_oe   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sample_en) begin
                rx_sh <= rx_next[DATA_W-2:0];
            end
            if (byte_done) begin
                rx_byte  <= rx_next;
                rx_valid <= 1'b1;
            end
            if (tx_load) begin
                tx_sh <= tx_byte;
            end
            if (drive_en) begin
                dat_o  <= tx_sh[DATA_W-1];
                tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                dat_oe <= 1'b1;
            end else if (drive_off) begin
                dat_oe <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dbg2w_slave.sv
module dbg2w_slave
    import dbg2w_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_clk_i,
    input  logic              dbg_dat_i,
    input  logic              next_is_read,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              dbg_dat_o,
    output logic              dbg_dat_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [NUM_LINES-1:0] raw_lines;
    line_ev_t             ev [NUM_LINES];

    assign raw_lines[LINE_CLK] = dbg_clk_i;
    assign raw_lines[LINE_DAT] = dbg_dat_i;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
        dbg2w_line_sync #(
            .STAGES   (SYNC_STAGES),
            .IDLE_LVL (1'b1)
        ) u_sync (
            .clk (clk),
            .rst (rst),
            .raw (raw_lines[g]),
            .ev  (ev[g])
        );
    end

    link_st_e         state;
    xfer_dir_e        dir;
    logic [CNT_W-1:0] bit_cnt;
    logic             start_det;
    logic             sample_en;
    logic             byte_done;
    logic             tx_load;
    logic             drive_en;
    logic             drive_off;

    // Observation points for the bound checker
    logic scl_hi;
    logic scl_rise;
    logic sda_rise;
    logic dir_rd;

    assign scl_hi   = ev[LINE_CLK].lvl;
    assign scl_rise = ev[LINE_CLK].rise;
    assign sda_rise = ev[LINE_DAT].rise;
    assign dir_rd   = (dir == DIR_RD);

    dbg2w_frame_ctrl #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_frame (
        .clk          (clk),
        .rst          (rst),
        .clk_ev       (ev[LINE_CLK]),
        .dat_ev       (ev[LINE_DAT]),
        .next_is_read (next_is_read),
        .state        (state),
        .dir          (dir),
        .bit_cnt      (bit_cnt),
        .start_det    (start_det),
        .sample_en    (sample_en),
        .byte_done    (byte_done),
        .tx_load      (tx_load),
        .drive_en     (drive_en),
        .drive_off    (drive_off)
    );

    dbg2w_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .dat_lvl   (ev[LINE_DAT].lvl),
        .sample_en (sample_en),
        .byte_done (byte_done),
        .tx_load   (tx_load),
        .drive_en  (drive_en),
        .drive_off (drive_off),
        .tx_byte   (tx_byte),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .dat_o     (dbg_dat_o),
        .dat_oe    (dbg_dat_oe)
    );

endmodule

// File: rtl/dbg2w_checker.sv
module dbg2w_checker
    import dbg2w_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input logic             clk,
    input logic             rst,
    input link_st_e         state,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             start_det,
    input logic             scl_hi,
    input logic             scl_rise,
    input logic             sda_rise,
    input logic             dir_rd,
    input logic             dbg_dat_o,
    input logic             dbg_dat_oe,
    input logic             rx_valid
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!dbg_dat_oe && !rx_valid));

    assert_idle_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!dbg_dat_oe && !rx_valid));

    assert_start_clears_R3: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (bit_cnt == '0 && !dbg_dat_oe && !dir_rd));

    assert_rise_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (sda_rise && scl_hi && !scl_rise) |=> ($stable(bit_cnt) && $stable(state)));

    assert_rx_after_edge_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(scl_rise));

    assert_count_range_R6: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(DATA_W));

    assert_drive_low_phase_R7: assert property (@(posedge clk) disable iff (rst)
        (scl_hi && $past(scl_hi)) |-> $stable(dbg_dat_o));

    assert_oe_rise_low_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(dbg_dat_oe) |-> (!scl_hi && dir_rd));

    assert_no_rx_on_drive_R8: assert property (@(posedge clk) disable iff (rst)
        !(dbg_dat_oe && rx_valid));

    assert_strobe_width_R11: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

endmodule

bind dbg2w_slave dbg2w_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .state      (state),
    .bit_cnt    (bit_cnt),
    .start_det  (start_det),
    .scl_hi     (scl_hi),
    .scl_rise   (scl_rise),
    .sda_rise   (sda_rise),
    .dir_rd     (dir_rd),
    .dbg_dat_o  (dbg_dat_o),
    .dbg_dat_oe (dbg_dat_oe),
    .rx_valid   (rx_valid)
);

// File: tb/tb_dbg2w_slave.sv
`timescale 1ns/1ps
module tb_dbg2w_slave;

    localparam int W = 8;
    localparam int H = 8;   // serial half period in system clocks

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         m_scl = 1'b1;
    logic         m_sda = 1'b1;
    logic         next_is_read = 1'b0;
    logic [W-1:0] tx_byte = '0;
    logic         dbg_dat_o;
    logic         dbg_dat_oe;
    logic [W-1:0] rx_byte;
    logic         rx_valid;
    logic         line;

    always #2.5 clk = ~clk;

    assign line = dbg_dat_oe ? dbg_dat_o : m_sda;

    dbg2w_slave #(.DATA_W(W), .SYNC_STAGES(2)) dut (
        .clk          (clk),
        .rst          (rst),
        .dbg_clk_i    (m_scl),
        .dbg_dat_i    (line),
        .next_is_read (next_is_read),
        .tx_byte      (tx_byte),
        .dbg_dat_o    (dbg_dat_o),
        .dbg_dat_oe   (dbg_dat_oe),
        .rx_byte      (rx_byte),
        .rx_valid     (rx_valid)
    );

    int checks = 0;
    int fails  = 0;
    int rx_seen = 0;
    logic [W-1:0] rx_q [$];
    logic [W-1:0] rd_q [$];
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on every receive strobe
    logic prev_v = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                rx_seen++;
                chk(!prev_v, "R11 strobe width", 1, 0);
                if (rx_q.size() == 0) begin
                    chk(1'b0, "R2 R8 unexpected rx_valid", int'(rx_byte), -1);
                end else begin
                    automatic logic [W-1:0] e = rx_q.pop_front();
                    chk(rx_byte == e, "R5 R6 rx byte", int'(rx_byte), int'(e));
                end
            end
            prev_v <= rx_valid;
        end
    end

    task automatic do_start();
        if (!m_sda) begin
            m_sda = 1'b1;       // rising data with clock high: must be ignored (R4)
            cyc(H);
        end
        m_sda = 1'b0;
        cyc(H);
    endtask

    task automatic ninth(input bit nrd, input logic [W-1:0] ntx);
        m_scl = 1'b0;
        cyc(H / 2);
        if (nrd) m_sda = 1'b1;
        next_is_read = nrd;
        tx_byte      = ntx;
        if (nrd) rd_q.push_back(ntx);
        cyc(H / 2);
        chk(dbg_dat_oe == 1'b0, "R8 oe released in ninth", int'(dbg_dat_oe), 0);
        m_scl = 1'b1;
        cyc(H);
    endtask

    task automatic write_byte(input logic [W-1:0] b, input bit glitch,
                              input bit nrd, input logic [W-1:0] ntx);
        rx_q.push_back(b);
        for (int i = W - 1; i >= 0; i--) begin
            m_scl = 1'b0;
            cyc(H / 2);
            m_sda = b[i];
            cyc(H / 2);
            m_scl = 1'b1;
            cyc(H / 2);
            if (glitch && !b[i] && i > 0) begin
                if (b[i-1]) m_sda = 1'b1;   // early rise while clock high (R4)
            end
            cyc(H / 2);
        end
        ninth(nrd, ntx);
    endtask

    task automatic read_byte(input bit nrd, input logic [W-1:0] ntx);
        logic [W-1:0] exp_b;
        logic [W-1:0] got;
        exp_b = rd_q.pop_front();
        got   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            m_scl = 1'b0;
            cyc(H);
            chk(dbg_dat_oe == 1'b1, "R7 oe during data cycle", int'(dbg_dat_oe), 1);
            got[i] = line;
            m_scl = 1'b1;
            cyc(H);
        end
        chk(got == exp_b, "R7 transmitted byte", int'(got), int'(exp_b));
        ninth(nrd, ntx);
    endtask

    initial begin
        int seen0;
        cyc(4);
        rst = 1'b0;
        cyc(2);
        chk(dbg_dat_oe == 1'b0, "R1 reset oe", int'(dbg_dat_oe), 0);
        chk(rx_valid == 1'b0, "R1 reset rx_valid", int'(rx_valid), 0);

        // R2: activity before any start
        for (int k = 0; k < 10; k++) begin
            m_scl = 1'b0;
            cyc(H / 2);
            m_sda = k[0];
            cyc(H / 2);
            m_scl = 1'b1;
            cyc(H / 2);
            if (!m_sda) m_sda = 1'b1;
            cyc(H / 2);
            chk(dbg_dat_oe == 1'b0, "R2 no drive before start", int'(dbg_dat_oe), 0);
        end
        chk(rx_seen == 0, "R2 no strobe before start", rx_seen, 0);

        // R3 R5 R6: start then back-to-back receive bytes
        do_start();
        write_byte(8'hA5, 1'b0, 1'b0, 8'h00);
        write_byte(8'h3C, 1'b0, 1'b0, 8'h00);
        // R4: data rises while clock high inside a byte
        write_byte(8'h55, 1'b1, 1'b0, 8'h00);
        chk(rx_seen == 3, "R5 R6 three strobes", rx_seen, 3);

        // R7 R8: turn to transmit twice, then back to receive
        write_byte(8'h12, 1'b0, 1'b1, 8'hC3);
        seen0 = rx_seen;
        read_byte(1'b1, 8'h5A);
        read_byte(1'b0, 8'h00);
        chk(rx_seen == seen0, "R8 no strobe on transmit", rx_seen, seen0);
        write_byte(8'hF0, 1'b0, 1'b0, 8'h00);

        // R9: master parks in the ninth cycle with clock high
        seen0 = rx_seen;
        cyc(60);
        chk(dbg_dat_oe == 1'b0, "R9 quiet while parked", int'(dbg_dat_oe), 0);
        chk(rx_seen == seen0, "R9 no strobe while parked", rx_seen, seen0);
        do_start();
        write_byte(8'h81, 1'b0, 1'b0, 8'h00);

        // R10: restart in the middle of a byte
        do_start();
        for (int i = 0; i < 3; i++) begin
            m_scl = 1'b0;
            cyc(H / 2);
            m_sda = i[0];
            cyc(H / 2);
            m_scl = 1'b1;
            cyc(H);
        end
        m_scl = 1'b0;
        cyc(H / 2);
        m_sda = 1'b1;
        cyc(H / 2);
        m_scl = 1'b1;
        cyc(H);
        m_sda = 1'b0;           // start while mid-byte
        cyc(H);
        write_byte(8'h96, 1'b0, 1'b0, 8'h00);

        cyc(20);
        chk(rx_q.size() == 0, "R10 scoreboard drained", rx_q.size(), 0);
        chk(dbg_dat_oe == 1'b0, "R9 final quiet", int'(dbg_dat_oe), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R6 actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule